// File: doc/BRIEF.md
# Weekday-Calendar Timekeeping Core

This core keeps wall-clock time in 24-hour form, a day-of-week count and a two-digit-year calendar. It advances on a one-pulse-per-second enable, so it runs from the system clock and needs no divided clock. A field-write port lets the time, weekday or date be changed at any moment. A view selector picks what the seven BCD digits show: weekday and hours/minutes/seconds, year/month/day, or a stopwatch.

The stopwatch has its own hundredths-of-a-second enable, a start/stop pulse and a clear pulse. It shares only the digit outputs with the clock and never changes the clock. Segment decoding, digit scanning and the generation of the enables belong to the surrounding logic. A blank digit is shown as code 0xF.

Top module: `wkcal_clock_core`

## Requirements
- R1: After reset the time is 00:00:00, the weekday is 1, the date is year 00, month 01, day 01, and the stopwatch is at 00:00.00 and stopped.
- R2: Each `tick_1hz` pulse advances the seconds. Seconds 59 become 00 and carry into the minutes, minutes 59 become 00 and carry into the hours, and hours 23 become 00.
- R3: The carry out of hour 23 advances the weekday and the day of month in the same cycle. Weekday 7 is followed by weekday 1.
- R4: Months 4, 6, 9 and 11 have 30 days and February has 29 days when the year is divisible by 4, 28 otherwise. All other months have 31 days. The day after the last day is day 1 of the next month, month 12 is followed by month 1 of the next year, and year 99 is followed by year 00.
- R5: When `set_we` is high, `set_val` (binary) is loaded into the field chosen by `set_sel`: 0 hour, 1 minute, 2 second, 3 weekday, 4 day, 5 month, 6 year. A write to any field other than seconds also clears the seconds.
- R6: In a cycle with an accepted write, a `tick_1hz` pulse is ignored and no carry takes place.
- R7: A write is rejected and changes nothing if any of these holds: hour is above 23, minute or second is above 59, weekday is outside 1..7, month is outside 1..12, day is 0 or larger than the current month's length, year is above 99, or the selector is 7. A `tick_1hz` in the same cycle is then processed normally.
- R8: An `sw_startstop` pulse toggles the stopwatch between running and stopped. While running, each `tick_100hz` advances the hundredths, 99 hundredths carry into seconds and 59 seconds carry into minutes. While stopped the count holds.
- R9: `sw_clear` zeroes the stopwatch and stops it. It wins over `sw_startstop` in the same cycle.
- R10: Stopwatch inputs never change the time or date, and `tick_1hz` never changes the stopwatch.
- R11: `digits[27:24]` is the leftmost digit and `digits[3:0]` the rightmost, each a BCD digit. `view_sel` 0 or 3 shows weekday, HH, MM, SS. `view_sel` 1 shows blank (0xF), YY, MM, DD. `view_sel` 2 shows blank, stopwatch minutes, seconds and hundredths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| tick_100hz | input | 1 | One-cycle pulse per hundredth of a second for the stopwatch |
| set_we | input | 1 | Field write request |
| set_sel | input | 3 | Field selector for a write |
| set_val | input | 7 | Binary value to write |
| view_sel | input | 2 | Display view selector |
| sw_startstop | input | 1 | Stopwatch start/stop toggle pulse |
| sw_clear | input | 1 | Stopwatch clear pulse |
| digits | output | 28 | Seven 4-bit BCD display digits |

## Verification
Two pairs of functions can fall in the same cycle.

- **Field write and second tick.** The bench drives `set_we` and `tick_1hz` in the same cycle, with seconds at 59, so that a carry would be due. It expects the written value, cleared seconds and unchanged minutes. It then repeats this with a rejected value, where the tick must take effect.
- **Stopwatch clear and start/stop.** The bench pulses `sw_clear` and `sw_startstop` together and judges that the count is zero and stays frozen under further hundredth ticks.

A reference model in the bench follows every cycle of a full-day sweep, a four-year day-by-day calendar sweep and a stopwatch run interleaved with second ticks.

// File: rtl/wkcal_pkg.sv
`timescale 1ns/1ps
// Shared widths, limits, field codes and helper functions for the
// weekday-calendar timekeeping core. Assumes all counts fit in 7 bits.
package wkcal_pkg;
    localparam int VAL_W  = 7;
    localparam int DIG_W  = 4;
    localparam int N_DIG  = 7;
    localparam int DISP_W = DIG_W * N_DIG;

    localparam logic [VAL_W-1:0] SEC_LAST  = 7'd59;
    localparam logic [VAL_W-1:0] MIN_LAST  = 7'd59;
    localparam logic [VAL_W-1:0] HOUR_LAST = 7'd23;
    localparam logic [VAL_W-1:0] MON_LAST  = 7'd12;
    localparam logic [VAL_W-1:0] YEAR_LAST = 7'd99;
    localparam logic [2:0]       WDAY_LAST = 3'd7;
    localparam logic [DIG_W-1:0] DIGIT_BLANK = 4'hF;

    typedef enum logic [2:0] {
        FLD_HOUR  = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_SEC   = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DAY   = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } field_e;

    // Days in a month; every fourth year (including 00) has a 29-day February.
    function automatic logic [VAL_W-1:0] month_len(input logic [VAL_W-1:0] mon,
                                                   input logic [VAL_W-1:0] yr);
        case (mon)
            7'd2:                    month_len = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11: month_len = 7'd30;
            default:                 month_len = 7'd31;
        endcase
    endfunction

    // Two BCD digits of a value below 100.
    function automatic logic [2*DIG_W-1:0] to_bcd2(input logic [VAL_W-1:0] v);
        to_bcd2 = {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction
endpackage

// File: rtl/wkcal_time_chain.sv
`timescale 1ns/1ps
// Seconds/minutes/hours chain in 24-hour form. Assumes wr_en is already
// range-checked; an accepted write has priority over the tick and clears
// seconds unless seconds is the written field. day_carry flags the 23:59:59
// rollover.
module wkcal_time_chain
    import wkcal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  field_e           wr_sel,
    input  logic [VAL_W-1:0] wr_val,
    output logic [VAL_W-1:0] hr,
    output logic [VAL_W-1:0] mn,
    output logic [VAL_W-1:0] sc,
    output logic             day_carry
);
    // Midnight carry: a tick that is not blocked by a write, at 23:59:59.
    always_comb begin
        day_carry = tick && !wr_en && (sc == SEC_LAST) && (mn == MIN_LAST) && (hr == HOUR_LAST);
    end

    // Counter update: write first, otherwise count on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr <= '0;
            mn <= '0;
            sc <= '0;
        end else if (wr_en) begin
            sc <= (wr_sel == FLD_SEC) ? wr_val : '0;
            if (wr_sel == FLD_HOUR) hr <= wr_val;
            if (wr_sel == FLD_MIN)  mn <= wr_val;
        end else if (tick) begin
            if (sc == SEC_LAST) begin
                sc <= '0;
                if (mn == MIN_LAST) begin
                    mn <= '0;
                    hr <= (hr == HOUR_LAST) ? '0 : hr + 7'd1;
                end else begin
                    mn <= mn + 7'd1;
                end
            end else begin
                sc <= sc + 7'd1;
            end
        end
    end
endmodule

// File: rtl/wkcal_calendar.sv
`timescale 1ns/1ps
// Weekday and year/month/day registers. Advances once per day carry;
// assumes writes are range-checked upstream. An out-of-length day
// (left by a month or year write) rolls to day 1 at the next carry.
module wkcal_calendar
    import wkcal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr_en,
    input  field_e           wr_sel,
    input  logic [VAL_W-1:0] wr_val,
    output logic [2:0]       wday,
    output logic [VAL_W-1:0] day,
    output logic [VAL_W-1:0] mon,
    output logic [VAL_W-1:0] yr,
    output logic [VAL_W-1:0] mlen
);
    // Length of the current month, also used for day-write checks.
    always_comb begin
        mlen = month_len(mon, yr);
    end

    // Calendar update: write first, otherwise advance on the day carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wday <= 3'd1;
            day  <= 7'd1;
            mon  <= 7'd1;
            yr   <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                FLD_WDAY:  wday <= wr_val[2:0];
                FLD_DAY:   day  <= wr_val;
                FLD_MONTH: mon  <= wr_val;
                FLD_YEAR:  yr   <= wr_val;
                default:   ;
            endcase
        end else if (adv) begin
            wday <= (wday == WDAY_LAST) ? 3'd1 : wday + 3'd1;
            if (day >= mlen) begin
                day <= 7'd1;
                if (mon == MON_LAST) begin
                    mon <= 7'd1;
                    yr  <= (yr == YEAR_LAST) ? '0 : yr + 7'd1;
                end else begin
                    mon <= mon + 7'd1;
                end
            end else begin
                day <= day + 7'd1;
            end
        end
    end
endmodule

// File: rtl/wkcal_stopwatch.sv
`timescale 1ns/1ps
// Elapsed-time counter in minutes/seconds/hundredths with its own enable.
// Assumes toggle and clear are single-cycle pulses; clear wins.
module wkcal_stopwatch
    import wkcal_pkg::*;
#(
    parameter int SUB_PER_SEC = 100,
    parameter int SEC_PER_MIN = 60,
    parameter int MIN_WRAP    = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             toggle,
    input  logic             clear,
    output logic [VAL_W-1:0] cs,
    output logic [VAL_W-1:0] ss,
    output logic [VAL_W-1:0] mm,
    output logic             running
);
    localparam logic [VAL_W-1:0] CS_LAST = VAL_W'(SUB_PER_SEC - 1);
    localparam logic [VAL_W-1:0] SS_LAST = VAL_W'(SEC_PER_MIN - 1);
    localparam logic [VAL_W-1:0] MM_LAST = VAL_W'(MIN_WRAP - 1);

    // Run flag and counters; counting uses the run state before a toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cs      <= '0;
            ss      <= '0;
            mm      <= '0;
            running <= 1'b0;
        end else begin
            if (toggle) running <= !running;
            if (running && tick) begin
                if (cs == CS_LAST) begin
                    cs <= '0;
                    if (ss == SS_LAST) begin
                        ss <= '0;
                        mm <= (mm == MM_LAST) ? '0 : mm + 7'd1;
                    end else begin
                        ss <= ss + 7'd1;
                    end
                end else begin
                    cs <= cs + 7'd1;
                end
            end
        end
    end
endmodule

// File: rtl/wkcal_digit_view.sv
`timescale 1ns/1ps
// Selects the seven display digits for the chosen view and converts the
// binary fields to BCD. Purely combinational; assumes every field is below 100.
module wkcal_digit_view
    import wkcal_pkg::*;
(
    input  logic [1:0]        view,
    input  logic [2:0]        wday,
    input  logic [VAL_W-1:0]  hr,
    input  logic [VAL_W-1:0]  mn,
    input  logic [VAL_W-1:0]  sc,
    input  logic [VAL_W-1:0]  yr,
    input  logic [VAL_W-1:0]  mon,
    input  logic [VAL_W-1:0]  day,
    input  logic [VAL_W-1:0]  sw_mm,
    input  logic [VAL_W-1:0]  sw_ss,
    input  logic [VAL_W-1:0]  sw_cs,
    output logic [DISP_W-1:0] digits
);
    // View multiplexer; codes other than date and stopwatch show the time.
    always_comb begin
        case (view)
            2'd1:    digits = {DIGIT_BLANK, to_bcd2(yr), to_bcd2(mon), to_bcd2(day)};
            2'd2:    digits = {DIGIT_BLANK, to_bcd2(sw_mm), to_bcd2(sw_ss), to_bcd2(sw_cs)};
            default: digits = {1'b0, wday, to_bcd2(hr), to_bcd2(mn), to_bcd2(sc)};
        endcase
    end
endmodule

// File: rtl/wkcal_clock_core.sv
`timescale 1ns/1ps
// Top of the weekday-calendar timekeeping core: validates field writes,
// ties the time chain to the calendar, runs the stopwatch beside them and
// drives seven BCD digits. Assumes the tick inputs are one-cycle pulses
// synchronous to clk.
module wkcal_clock_core
    import wkcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              tick_100hz,
    input  logic              set_we,
    input  logic [2:0]        set_sel,
    input  logic [VAL_W-1:0]  set_val,
    input  logic [1:0]        view_sel,
    input  logic              sw_startstop,
    input  logic              sw_clear,
    output logic [DISP_W-1:0] digits
);
    field_e           sel;
    logic             val_ok;
    logic             wr_en;
    logic             day_carry;
    logic [VAL_W-1:0] hr, mn, sc, day, mon, yr, mlen;
    logic [2:0]       wday;
    logic [VAL_W-1:0] sw_cs, sw_ss, sw_mm;
    logic             sw_run;

    // Range check of the written value against its field.
    always_comb begin
        sel = field_e'(set_sel);
        case (sel)
            FLD_HOUR:  val_ok = (set_val <= HOUR_LAST);
            FLD_MIN:   val_ok = (set_val <= MIN_LAST);
            FLD_SEC:   val_ok = (set_val <= SEC_LAST);
            FLD_WDAY:  val_ok = (set_val >= 7'd1) && (set_val <= 7'(WDAY_LAST));
            FLD_DAY:   val_ok = (set_val >= 7'd1) && (set_val <= mlen);
            FLD_MONTH: val_ok = (set_val >= 7'd1) && (set_val <= MON_LAST);
            FLD_YEAR:  val_ok = (set_val <= YEAR_LAST);
            default:   val_ok = 1'b0;
        endcase
        wr_en = set_we && val_ok;
    end

    wkcal_time_chain u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(wr_en),
        .wr_sel(sel), .wr_val(set_val), .hr(hr), .mn(mn), .sc(sc),
        .day_carry(day_carry)
    );

    wkcal_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(day_carry), .wr_en(wr_en),
        .wr_sel(sel), .wr_val(set_val), .wday(wday), .day(day),
        .mon(mon), .yr(yr), .mlen(mlen)
    );

    wkcal_stopwatch #(.SUB_PER_SEC(100), .SEC_PER_MIN(60), .MIN_WRAP(60)) u_sw (
        .clk(clk), .rst_n(rst_n), .tick(tick_100hz), .toggle(sw_startstop),
        .clear(sw_clear), .cs(sw_cs), .ss(sw_ss), .mm(sw_mm), .running(sw_run)
    );

    wkcal_digit_view u_view (
        .view(view_sel), .wday(wday), .hr(hr), .mn(mn), .sc(sc),
        .yr(yr), .mon(mon), .day(day), .sw_mm(sw_mm), .sw_ss(sw_ss),
        .sw_cs(sw_cs), .digits(digits)
    );
endmodule

// File: rtl/wkcal_clock_checker.sv
`timescale 1ns/1ps
// Temporal checks on the timekeeping core, attached to every instance of
// the top through bind. Assumes synchronous active-low reset.
module wkcal_clock_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       set_we,
    input logic       wr_en,
    input logic [2:0] set_sel,
    input logic [6:0] hr,
    input logic [6:0] mn,
    input logic [6:0] sc,
    input logic [2:0] wday,
    input logic [6:0] day,
    input logic [6:0] mon,
    input logic [6:0] yr,
    input logic       sw_clear,
    input logic [6:0] sw_cs,
    input logic [6:0] sw_ss,
    input logic [6:0] sw_mm,
    input logic       sw_run
);
    assert_sec_roll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !set_we && sc == 7'd59) |=> (sc == 7'd0));

    assert_wday_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !set_we && hr == 7'd23 && mn == 7'd59 && sc == 7'd59 && wday == 3'd7)
        |=> (wday == 3'd1));

    assert_month_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mon >= 7'd1) && (mon <= 7'd12) && (day >= 7'd1) && (day <= 7'd31));

    assert_write_clears_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_sel != 3'd2) |=> (sc == 7'd0));

    assert_write_blocks_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_sel == 3'd2) |=> ($stable(mn) && $stable(hr)));

    assert_reject_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !wr_en && !tick_1hz)
        |=> ($stable(hr) && $stable(mn) && $stable(sc) && $stable(wday)
             && $stable(day) && $stable(mon) && $stable(yr)));

    assert_clear_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (!sw_run && sw_cs == 7'd0 && sw_ss == 7'd0 && sw_mm == 7'd0));

    assert_time_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !set_we)
        |=> ($stable(hr) && $stable(mn) && $stable(sc) && $stable(wday) && $stable(day)));
endmodule

bind wkcal_clock_core wkcal_clock_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .set_we(set_we),
    .wr_en(wr_en), .set_sel(set_sel), .hr(hr), .mn(mn), .sc(sc),
    .wday(wday), .day(day), .mon(mon), .yr(yr), .sw_clear(sw_clear),
    .sw_cs(sw_cs), .sw_ss(sw_ss), .sw_mm(sw_mm), .sw_run(sw_run)
);

// File: tb/sim_wkcal_clock_core.sv
`timescale 1ns/1ps
// Self-checking bench: an arithmetic reference model follows every cycle
// through a day sweep, a four-year calendar sweep and stopwatch runs.
module sim_wkcal_clock_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0, tick_100hz = 1'b0, set_we = 1'b0;
    logic [2:0]  set_sel = 3'd0;
    logic [6:0]  set_val = 7'd0;
    logic [1:0]  view_sel = 2'd0;
    logic        sw_startstop = 1'b0, sw_clear = 1'b0;
    logic [27:0] digits;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int m_h = 0, m_m = 0, m_s = 0, m_wd = 1, m_d = 1, m_mo = 1, m_y = 0;
    int w_cs = 0, w_ss = 0, w_mm = 0;
    bit w_run = 1'b0;

    always #2.5 clk = ~clk;

    wkcal_clock_core u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_100hz(tick_100hz),
        .set_we(set_we), .set_sel(set_sel), .set_val(set_val), .view_sel(view_sel),
        .sw_startstop(sw_startstop), .sw_clear(sw_clear), .digits(digits)
    );

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic bit wr_valid(int sel, int v);
        case (sel)
            0: return v <= 23;
            1, 2: return v <= 59;
            3: return v >= 1 && v <= 7;
            4: return v >= 1 && v <= mlen(m_mo, m_y);
            5: return v >= 1 && v <= 12;
            6: return v <= 99;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] b2(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [27:0] expect_view(int v);
        if (v == 1) return {4'hF, b2(m_y), b2(m_mo), b2(m_d)};
        if (v == 2) return {4'hF, b2(w_mm), b2(w_ss), b2(w_cs)};
        return {4'(m_wd), b2(m_h), b2(m_m), b2(m_s)};
    endfunction

    // Reference model of one clock cycle for the given stimulus.
    task automatic model_step(bit t1, bit t100, bit we, int sel, int val, bit tog, bit clr);
        if (we && wr_valid(sel, val)) begin
            m_s = (sel == 2) ? val : 0;
            if (sel == 0) m_h = val;
            if (sel == 1) m_m = val;
            if (sel == 3) m_wd = val;
            if (sel == 4) m_d = val;
            if (sel == 5) m_mo = val;
            if (sel == 6) m_y = val;
        end else if (t1) begin
            m_s++;
            if (m_s == 60) begin m_s = 0; m_m++; end
            if (m_m == 60) begin m_m = 0; m_h++; end
            if (m_h == 24) begin
                m_h = 0;
                m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                if (m_d >= mlen(m_mo, m_y)) begin
                    m_d = 1; m_mo++;
                    if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
                end else m_d++;
            end
        end
        if (clr) begin
            w_cs = 0; w_ss = 0; w_mm = 0; w_run = 1'b0;
        end else begin
            if (w_run && t100) begin
                w_cs++;
                if (w_cs == 100) begin w_cs = 0; w_ss++; end
                if (w_ss == 60) begin w_ss = 0; w_mm = (w_mm + 1) % 60; end
            end
            if (tog) w_run = !w_run;
        end
    endtask

    // Drive one cycle of stimulus, clock it in, then update the model.
    task automatic cyc(bit t1, bit t100, bit we, int sel, int val, bit tog, bit clr);
        tick_1hz = t1; tick_100hz = t100; set_we = we;
        set_sel = 3'(sel); set_val = 7'(val); sw_startstop = tog; sw_clear = clr;
        @(posedge clk);
        #1;
        tick_1hz = 1'b0; tick_100hz = 1'b0; set_we = 1'b0; sw_startstop = 1'b0; sw_clear = 1'b0;
        model_step(t1, t100, we, sel, val, tog, clr);
    endtask

    task automatic wr(int sel, int val);
        cyc(1'b0, 1'b0, 1'b1, sel, val, 1'b0, 1'b0);
    endtask

    task automatic check_view(int v, string req);
        logic [27:0] e;
        view_sel = 2'(v);
        #0.5;
        e = expect_view(v);
        checks++;
        if (digits !== e) begin
            fails++;
            $display("FAIL %s view=%0d actual=%h expected=%h", req, v, digits, e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (R1) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values in every view, code 3 showing the time view (R11)
        check_view(0, "R1"); check_view(1, "R1"); check_view(2, "R1");
        check_view(3, "R11");

        // R2/R3: a full day of second ticks, one per cycle
        for (int i = 0; i < 86400; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
            check_view(0, "R2");
        end
        check_view(1, "R3");

        // R4/R3: four years day by day by presetting 23:59:59 and ticking
        for (int d = 0; d < 1461; d++) begin
            wr(0, 23); wr(1, 59); wr(2, 59);
            cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
            check_view(1, "R4");
            check_view(0, "R3");
        end

        // R4: year 99 wraps to 00 at the end of December
        wr(6, 99); wr(5, 12); wr(4, 31); wr(3, 7);
        wr(0, 23); wr(1, 59); wr(2, 59);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        check_view(1, "R4"); check_view(0, "R3");

        // R5: writes load fields and clear seconds
        wr(0, 10); wr(2, 37); check_view(0, "R5");
        wr(1, 20); check_view(0, "R5");
        wr(5, 2); wr(6, 23); wr(4, 28); check_view(1, "R5");

        // R6: write with a tick at xx:xx:59 - no carry, write wins
        wr(2, 59);
        cyc(1'b1, 1'b0, 1'b1, 1, 30, 1'b0, 1'b0); check_view(0, "R6");
        wr(2, 59);
        cyc(1'b1, 1'b0, 1'b1, 2, 45, 1'b0, 1'b0); check_view(0, "R6");

        // R7: rejected writes leave all fields unchanged
        wr(5, 4); wr(4, 1); wr(2, 30);
        wr(0, 24);  check_view(0, "R7");
        wr(1, 60);  check_view(0, "R7");
        wr(2, 60);  check_view(0, "R7");
        wr(3, 0);   check_view(0, "R7");
        wr(3, 8);   check_view(0, "R7");
        wr(4, 31);  check_view(1, "R7");
        wr(4, 0);   check_view(1, "R7");
        wr(5, 13);  check_view(1, "R7");
        wr(5, 0);   check_view(1, "R7");
        wr(6, 100); check_view(1, "R7");
        wr(7, 5);   check_view(0, "R7");
        // rejected write in a tick cycle: the tick still counts
        wr(2, 59);
        cyc(1'b1, 1'b0, 1'b1, 0, 30, 1'b0, 1'b0); check_view(0, "R7");

        // R8/R10: stopwatch run with occasional second ticks
        cyc(1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0);
        for (int i = 0; i < 6150; i++) begin
            cyc((i % 7) == 3, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
            check_view(2, "R8");
            if (i % 50 == 0) check_view(0, "R10");
        end
        // R8: stop, then ticks have no effect
        cyc(1'b0, 1'b1, 1'b0, 0, 0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
        end
        check_view(2, "R8");
        // R9: clear together with start/stop leaves it zero and stopped
        cyc(1'b0, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 0, 0, 1'b1, 1'b1);
        check_view(2, "R9");
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
        end
        check_view(2, "R9");
        check_view(0, "R10");
        check_view(1, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule